// File: doc/BRIEF.md
# Text Window Access Decoder

This block sits between a CPU byte/word bus and the storage behind a 20 KB display window. The low 16 KB of the window hold text cells. The block decides whether each CPU write is stored, where it lands, and which cell must be redrawn. The 4 KB above the text area is a character window. It gives access to a font RAM through two pointers that a neighbouring block supplies: the high pointer and the low pointer. Address parity selects which pointer a byte uses.

Text storage and font storage both sit outside the block. The block drives two byte write lanes toward the text RAM, each with the index of the cell it touches. It drives one write port and two combinational read ports toward the font RAM. It also keeps two sticky flags, one for text changes and one for font writes. The display side clears both flags with a single clear strobe. Text-area reads are served by the text RAM directly, so the block returns data only for character-window reads. Words are little-endian: the low byte sits at the lower address.

Top module: `txwin_decoder`

## Requirements
- R1: A byte write to offset 0x0000–0x1FFF is always stored on lane 0 at its own offset, and its cell index is (offset >> 1) & 0xFFF.
- R2: A byte write to 0x2000–0x3FDF is stored only when the offset is even. Odd offsets produce no text or font write.
- R3: A byte write to 0x3FE0–0x3FFF is stored only when the offset is even and either offset bit 1 is 0 or sw_en_i is 1.
- R4: In 0x4000–0x4FFF, a byte write goes to font RAM only when the offset is odd and font_wen_i is 1. The font address is font_hi_i + offset[4:1], modulo the font size, and the data is the low data byte.
- R5: A read whose start offset is in 0x4000–0x4FFF returns font bytes. For an even offset the low byte uses font_lo_i + offset[4:1] and the high byte uses font_hi_i + offset[4:1]. For an odd offset the low byte uses font_hi_i + offset[4:1] and the high byte uses font_lo_i + ((offset+1) >> 1)[3:0]. A byte read, or a word read at 0x4FFF, returns 0xFF in the upper byte. Any other read returns 0xFFFF.
- R6: A word write starting at 0x0000–0x1FFF stores the low data byte at the offset on lane 0 and the high data byte at offset+1 on lane 1. At 0x1FFF this marks cells 0xFFF and 0x000.
- R7: A word write starting in 0x2000–0x3FFE writes one byte on lane 0. At an odd offset that byte is the high data byte, placed at offset+1. At an even offset it is the low data byte, placed at the offset. From a start offset of 0x3FE0 or higher, the write-protect rule of R3 applies to the adjusted offset. A word write starting in 0x3FFF–0x4FFF is a font write when font_wen_i is 1. Its data is the high byte for an odd offset and the low byte for an even one, and its address is as in R4.
- R8: text_dirty_o becomes 1 on the clock edge after any stored text byte and stays 1. A clr_i with no text write clears it on the next edge. A write in the same cycle as clr_i wins.
- R9: font_flag_o becomes 1 on the edge after any font write. It is cleared by clr_i with the same priority rule as R8.
- R10: With req_i low, or at offsets 0x5000 and above, no text or font write occurs and reads return 0xFFFF.
- R11: After reset both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| addr_i | input | AW (15) | Byte offset into the window |
| wdata_i | input | 16 | Write data, low byte at the lower address |
| rdata_o | output | 16 | Read data |
| sw_en_i | input | 1 | Unlocks the protected switch bytes |
| font_wen_i | input | 1 | Enables writes through the character window |
| font_hi_i | input | FONT_AW (8) | High font pointer |
| font_lo_i | input | FONT_AW (8) | Low font pointer |
| txt_we_o | output | 2 | Text byte write enables, one per lane |
| txt_addr0_o | output | 14 | Lane 0 text byte address |
| txt_addr1_o | output | 14 | Lane 1 text byte address |
| txt_data0_o | output | 8 | Lane 0 write byte |
| txt_data1_o | output | 8 | Lane 1 write byte |
| cell_idx0_o | output | 12 | Cell marked by lane 0 |
| cell_idx1_o | output | 12 | Cell marked by lane 1 |
| fnt_we_o | output | 1 | Font RAM write enable |
| fnt_waddr_o | output | FONT_AW (8) | Font RAM write address |
| fnt_wdata_o | output | 8 | Font RAM write byte |
| fnt_raddr0_o | output | FONT_AW (8) | Font RAM read address, low result byte |
| fnt_raddr1_o | output | FONT_AW (8) | Font RAM read address, high result byte |
| fnt_rdata0_i | input | 8 | Font RAM data for fnt_raddr0_o |
| fnt_rdata1_i | input | 8 | Font RAM data for fnt_raddr1_o |
| clr_i | input | 1 | Clears both sticky flags |
| text_dirty_o | output | 1 | Sticky text-changed flag |
| font_flag_o | output | 1 | Sticky font-written flag |

## Verification
The bench sweeps every offset of the window for byte and word writes, with both switch and font enables off and then on, so each region edge is hit exactly. A design that judged the switch bytes on the unadjusted word offset would accept or refuse the wrong write at 0x3FE1 and 0x3FFD. A design with a missing carry would mark cell 0x1000 instead of cell 0 for the word at 0x1FFF. A design that treated the word at 0x3FFF as a text write would write text instead of font. The read sweep walks across the character window and catches a swapped pointer choice for odd offsets, a missing wrap of the index at odd offsets, and a wrong upper byte at 0x4FFF. The flag sequences check that a set and a clear in the same cycle leave the flag set, and that rejected writes leave the flags untouched.

// File: rtl/txwin_pkg.sv
package txwin_pkg;
   // byte address width of the text area and the cell index width it implies
   localparam int unsigned TXT_AW = 14;
   localparam int unsigned CELL_W = TXT_AW - 2;
   // font window index: 16 bytes selected by offset[4:1]
   localparam int unsigned IDX_W  = 4;

   localparam logic [14:0] OFS_EVEN = 15'h2000;
   localparam logic [14:0] OFS_SW   = 15'h3FE0;
   localparam logic [14:0] OFS_CG   = 15'h4000;
   localparam logic [14:0] OFS_END  = 15'h5000;

   typedef enum logic [2:0] {
      RG_FREE,
      RG_EVEN,
      RG_SW,
      RG_CG,
      RG_NONE
   } region_e;
endpackage

// File: rtl/txwin_region.sv
module txwin_region
   import txwin_pkg::*;
#(
   parameter int unsigned AW = 15
) (
   input  logic [AW-1:0] addr_i,
   input  logic          word_i,
   output region_e       region_o
);
   localparam logic [AW-1:0] LIM_EVEN = AW'(OFS_EVEN);
   localparam logic [AW-1:0] LIM_SW   = AW'(OFS_SW);
   localparam logic [AW-1:0] LIM_CG   = AW'(OFS_CG);
   localparam logic [AW-1:0] LIM_END  = AW'(OFS_END);
   localparam logic [AW-1:0] LAST_TXT = LIM_CG - AW'(1);

   always_comb begin
      if (addr_i < LIM_EVEN) begin
         region_o = RG_FREE;
      end else if (addr_i < LIM_SW) begin
         region_o = RG_EVEN;
      end else if (addr_i < LIM_CG) begin
         // a word that starts on the last text byte is steered to the font side
         region_o = (word_i && (addr_i == LAST_TXT)) ? RG_CG : RG_SW;
      end else if (addr_i < LIM_END) begin
         region_o = RG_CG;
      end else begin
         region_o = RG_NONE;
      end
   end
endmodule

// File: rtl/txwin_wrpath.sv
module txwin_wrpath
   import txwin_pkg::*;
#(
   parameter int unsigned FONT_AW = 8
) (
   input  logic               acc_wr_i,
   input  logic               word_i,
   input  logic [TXT_AW-1:0]  addr_i,
   input  logic [15:0]        wdata_i,
   input  region_e            region_i,
   input  logic               sw_en_i,
   input  logic               font_wen_i,
   input  logic [FONT_AW-1:0] font_hi_i,
   output logic [1:0]         txt_we_o,
   output logic [TXT_AW-1:0]  txt_addr0_o,
   output logic [TXT_AW-1:0]  txt_addr1_o,
   output logic [7:0]         txt_data0_o,
   output logic [7:0]         txt_data1_o,
   output logic               fnt_we_o,
   output logic [FONT_AW-1:0] fnt_waddr_o,
   output logic [7:0]         fnt_wdata_o
);
   localparam int unsigned PAD = FONT_AW - IDX_W;

   logic              shift;
   logic [TXT_AW-1:0] eff_addr;
   logic [7:0]        eff_byte;
   logic              sw_ok;
   logic              even_ok;

   // an odd word in the even-only area moves its upper byte to the next even byte
   assign shift    = word_i & addr_i[0];
   assign eff_addr = addr_i + TXT_AW'(shift);
   assign eff_byte = shift ? wdata_i[15:8] : wdata_i[7:0];
   assign sw_ok    = ~eff_addr[1] | sw_en_i;
   assign even_ok  = word_i | ~addr_i[0];

   assign txt_addr0_o = (region_i == RG_FREE) ? addr_i : eff_addr;
   assign txt_data0_o = (region_i == RG_FREE) ? wdata_i[7:0] : eff_byte;
   assign txt_addr1_o = addr_i + TXT_AW'(1);
   assign txt_data1_o = wdata_i[15:8];

   assign fnt_waddr_o = font_hi_i + {{PAD{1'b0}}, addr_i[IDX_W:1]};
   assign fnt_wdata_o = eff_byte;

   always_comb begin
      txt_we_o = 2'b00;
      fnt_we_o = 1'b0;
      if (acc_wr_i) begin
         unique case (region_i)
            RG_FREE: txt_we_o = {word_i, 1'b1};
            RG_EVEN: txt_we_o = {1'b0, even_ok};
            RG_SW:   txt_we_o = {1'b0, even_ok & sw_ok};
            RG_CG:   fnt_we_o = font_wen_i & (word_i | addr_i[0]);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/txwin_rdpath.sv
module txwin_rdpath
   import txwin_pkg::*;
#(
   parameter int unsigned AW      = 15,
   parameter int unsigned FONT_AW = 8
) (
   input  logic                    acc_rd_i,
   input  logic                    word_i,
   input  logic [AW-1:0]           addr_i,
   input  logic [FONT_AW-1:0]      font_hi_i,
   input  logic [FONT_AW-1:0]      font_lo_i,
   output logic [1:0][FONT_AW-1:0] fnt_raddr_o,
   input  logic [1:0][7:0]         fnt_rdata_i,
   output logic [15:0]             rdata_o
);
   localparam int unsigned   PAD      = FONT_AW - IDX_W;
   localparam logic [AW-1:0] LIM_CG   = AW'(OFS_CG);
   localparam logic [AW-1:0] LIM_END  = AW'(OFS_END);
   localparam logic [AW-1:0] LAST_CG  = LIM_END - AW'(1);

   // lane 0 feeds the low result byte, lane 1 the high one
   for (genvar l = 0; l < 2; l++) begin : g_lane
      logic             use_hi;
      logic             step;
      logic [IDX_W-1:0] idx;
      assign use_hi = addr_i[0] ^ 1'(l);
      assign step   = (l == 1) ? addr_i[0] : 1'b0;
      assign idx    = addr_i[IDX_W:1] + IDX_W'(step);
      assign fnt_raddr_o[l] = (use_hi ? font_hi_i : font_lo_i) + {{PAD{1'b0}}, idx};
   end

   logic in_cg;
   assign in_cg = (addr_i >= LIM_CG) && (addr_i < LIM_END);

   always_comb begin
      if (!acc_rd_i || !in_cg) begin
         rdata_o = 16'hFFFF;
      end else if (!word_i || (addr_i == LAST_CG)) begin
         rdata_o = {8'hFF, fnt_rdata_i[0]};
      end else begin
         rdata_o = {fnt_rdata_i[1], fnt_rdata_i[0]};
      end
   end
endmodule

// File: rtl/txwin_decoder.sv
module txwin_decoder
   import txwin_pkg::*;
#(
   parameter int unsigned AW      = 15,
   parameter int unsigned FONT_AW = 8
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    req_i,
   input  logic                    we_i,
   input  logic                    word_i,
   input  logic [AW-1:0]           addr_i,
   input  logic [15:0]             wdata_i,
   output logic [15:0]             rdata_o,
   input  logic                    sw_en_i,
   input  logic                    font_wen_i,
   input  logic [FONT_AW-1:0]      font_hi_i,
   input  logic [FONT_AW-1:0]      font_lo_i,
   output logic [1:0]              txt_we_o,
   output logic [TXT_AW-1:0]       txt_addr0_o,
   output logic [TXT_AW-1:0]       txt_addr1_o,
   output logic [7:0]              txt_data0_o,
   output logic [7:0]              txt_data1_o,
   output logic [CELL_W-1:0]       cell_idx0_o,
   output logic [CELL_W-1:0]       cell_idx1_o,
   output logic                    fnt_we_o,
   output logic [FONT_AW-1:0]      fnt_waddr_o,
   output logic [7:0]              fnt_wdata_o,
   output logic [FONT_AW-1:0]      fnt_raddr0_o,
   output logic [FONT_AW-1:0]      fnt_raddr1_o,
   input  logic [7:0]              fnt_rdata0_i,
   input  logic [7:0]              fnt_rdata1_i,
   input  logic                    clr_i,
   output logic                    text_dirty_o,
   output logic                    font_flag_o
);
   if (AW < 15) begin : g_bad_aw
      $error("txwin_decoder: AW must cover the 20 KB window");
   end
   if (FONT_AW <= IDX_W) begin : g_bad_font
      $error("txwin_decoder: FONT_AW must exceed the font index width");
   end

   logic    acc_wr;
   logic    acc_rd;
   region_e region;

   assign acc_wr = req_i & we_i;
   assign acc_rd = req_i & ~we_i;

   txwin_region #(.AW(AW)) u_region (
      .addr_i   (addr_i),
      .word_i   (word_i),
      .region_o (region)
   );

   txwin_wrpath #(.FONT_AW(FONT_AW)) u_wr (
      .acc_wr_i    (acc_wr),
      .word_i      (word_i),
      .addr_i      (addr_i[TXT_AW-1:0]),
      .wdata_i     (wdata_i),
      .region_i    (region),
      .sw_en_i     (sw_en_i),
      .font_wen_i  (font_wen_i),
      .font_hi_i   (font_hi_i),
      .txt_we_o    (txt_we_o),
      .txt_addr0_o (txt_addr0_o),
      .txt_addr1_o (txt_addr1_o),
      .txt_data0_o (txt_data0_o),
      .txt_data1_o (txt_data1_o),
      .fnt_we_o    (fnt_we_o),
      .fnt_waddr_o (fnt_waddr_o),
      .fnt_wdata_o (fnt_wdata_o)
   );

   logic [1:0][FONT_AW-1:0] raddr;

   txwin_rdpath #(.AW(AW), .FONT_AW(FONT_AW)) u_rd (
      .acc_rd_i    (acc_rd),
      .word_i      (word_i),
      .addr_i      (addr_i),
      .font_hi_i   (font_hi_i),
      .font_lo_i   (font_lo_i),
      .fnt_raddr_o (raddr),
      .fnt_rdata_i ({fnt_rdata1_i, fnt_rdata0_i}),
      .rdata_o     (rdata_o)
   );

   assign fnt_raddr0_o = raddr[0];
   assign fnt_raddr1_o = raddr[1];

   // each lane marks the cell holding its byte
   assign cell_idx0_o = txt_addr0_o[CELL_W:1];
   assign cell_idx1_o = txt_addr1_o[CELL_W:1];

   // sticky flags: a set in the clearing cycle survives
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         text_dirty_o <= 1'b0;
         font_flag_o  <= 1'b0;
      end else begin
         text_dirty_o <= (text_dirty_o & ~clr_i) | (|txt_we_o);
         font_flag_o  <= (font_flag_o & ~clr_i) | fnt_we_o;
      end
   end
endmodule

// File: rtl/txwin_checker.sv
module txwin_checker #(
   parameter int unsigned AW = 15
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          req_i,
   input logic          we_i,
   input logic          word_i,
   input logic [AW-1:0] addr_i,
   input logic          sw_en_i,
   input logic          clr_i,
   input logic [15:0]   rdata_o,
   input logic [1:0]    txt_we_o,
   input logic [13:0]   txt_addr0_o,
   input logic          fnt_we_o,
   input logic          text_dirty_o,
   input logic          font_flag_o
);
   localparam logic [AW-1:0] A_EVEN = AW'(15'h2000);
   localparam logic [AW-1:0] A_SW   = AW'(15'h3FE0);
   localparam logic [AW-1:0] A_END  = AW'(15'h5000);

   // R2: odd byte writes in the even-only area are dropped
   a_r2_odd_byte_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && !word_i && addr_i >= A_EVEN && addr_i < A_SW && addr_i[0])
      |-> (txt_we_o == 2'b00 && !fnt_we_o));

   // R3: a stored switch byte with bit 1 set needs the switch enable
   a_r3_switch_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (txt_we_o[0] && txt_addr0_o >= 14'h3FE0 && txt_addr0_o[1]) |-> sw_en_i);

   // R6: the second lane only fires for words, together with the first
   a_r6_lane_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
      txt_we_o[1] |-> (word_i && txt_we_o[0]));

   // R8: a stored text byte raises the sticky flag
   a_r8_dirty_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|txt_we_o) |=> text_dirty_o);

   // R8: a clear with no write drops the flag
   a_r8_dirty_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && txt_we_o == 2'b00) |=> !text_dirty_o);

   // R9: a font write raises the font flag
   a_r9_font_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fnt_we_o |=> font_flag_o);

   // R10: idle cycles and offsets past the window touch nothing
   a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!req_i || addr_i >= A_END) |-> (txt_we_o == 2'b00 && !fnt_we_o && rdata_o == 16'hFFFF));
endmodule

bind txwin_decoder txwin_checker #(.AW(AW)) u_chk (.*);

// File: tb/tb_txwin_decoder.sv
module tb_txwin_decoder;
   localparam int CLK_PERIOD = 10;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        req_i = 1'b0, we_i = 1'b0, word_i = 1'b0;
   logic [14:0] addr_i = '0;
   logic [15:0] wdata_i = '0;
   logic [15:0] rdata_o;
   logic        sw_en_i = 1'b0, font_wen_i = 1'b0;
   logic [7:0]  font_hi_i = '0, font_lo_i = '0;
   logic [1:0]  txt_we_o;
   logic [13:0] txt_addr0_o, txt_addr1_o;
   logic [7:0]  txt_data0_o, txt_data1_o;
   logic [11:0] cell_idx0_o, cell_idx1_o;
   logic        fnt_we_o;
   logic [7:0]  fnt_waddr_o, fnt_wdata_o, fnt_raddr0_o, fnt_raddr1_o;
   logic [7:0]  fnt_rdata0_i, fnt_rdata1_i;
   logic        clr_i = 1'b0;
   logic        text_dirty_o, font_flag_o;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   function automatic int fv(int x);
      return ((x % 256) * 37 + 11) % 256;
   endfunction

   assign fnt_rdata0_i = 8'(fv(int'(fnt_raddr0_o)));
   assign fnt_rdata1_i = 8'(fv(int'(fnt_raddr1_o)));

   txwin_decoder dut (.*);

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string wtag(bit w, int a);
      if (a >= 'h5000) return "R10";
      if (w) return (a <= 'h1FFF) ? "R6" : "R7";
      if (a < 'h2000) return "R1";
      if (a < 'h3FE0) return "R2";
      if (a < 'h4000) return "R3";
      return "R4";
   endfunction

   // expected write outcome computed from the requirement text
   task automatic check_write(bit w, int a, int d, bit sw, bit fw, int hi);
      int lo_b = d % 256;
      int hi_b = d / 256;
      int e_we0 = 0, e_we1 = 0, e_a0 = 0, e_d0 = 0, e_fwe = 0, e_fa = 0, e_fd = 0;
      int t;
      int e_we;
      string tg = wtag(w, a);
      if (!w) begin
         if (a < 'h2000) begin e_we0 = 1; e_a0 = a; e_d0 = lo_b; end
         else if (a < 'h3FE0) begin
            if (a % 2 == 0) begin e_we0 = 1; e_a0 = a; e_d0 = lo_b; end
         end else if (a < 'h4000) begin
            if (a % 2 == 0 && ((a / 2) % 2 == 0 || sw)) begin e_we0 = 1; e_a0 = a; e_d0 = lo_b; end
         end else if (a < 'h5000) begin
            if (a % 2 == 1 && fw) begin e_fwe = 1; e_fa = (hi + (a / 2) % 16) % 256; e_fd = lo_b; end
         end
      end else begin
         if (a <= 'h1FFF) begin e_we0 = 1; e_we1 = 1; e_a0 = a; e_d0 = lo_b; end
         else if (a < 'h3FFF) begin
            t = a + (a % 2);
            if (a < 'h3FE0 || (t / 2) % 2 == 0 || sw) begin
               e_we0 = 1; e_a0 = t; e_d0 = (a % 2) ? hi_b : lo_b;
            end
         end else if (a < 'h5000) begin
            if (fw) begin e_fwe = 1; e_fa = (hi + (a / 2) % 16) % 256; e_fd = (a % 2) ? hi_b : lo_b; end
         end
      end
      e_we = e_we1 * 2 + e_we0;
      chk(int'(txt_we_o) == e_we && int'(fnt_we_o) == e_fwe, tg, $sformatf("enables @%0h w=%0d", a, w),
          int'(txt_we_o) * 16 + int'(fnt_we_o), e_we * 16 + e_fwe);
      if (e_we0 == 1)
         chk(int'(txt_addr0_o) == e_a0 && int'(txt_data0_o) == e_d0 && int'(cell_idx0_o) == (e_a0 / 2) % 4096,
             tg, $sformatf("lane0 @%0h", a), int'(txt_addr0_o) * 256 + int'(txt_data0_o),
             e_a0 * 256 + e_d0);
      if (e_we1 == 1)
         chk(int'(txt_addr1_o) == a + 1 && int'(txt_data1_o) == hi_b && int'(cell_idx1_o) == ((a + 1) / 2) % 4096,
             tg, $sformatf("lane1 @%0h", a), int'(cell_idx1_o), ((a + 1) / 2) % 4096);
      if (e_fwe == 1)
         chk(int'(fnt_waddr_o) == e_fa && int'(fnt_wdata_o) == e_fd, tg, $sformatf("font @%0h", a),
             int'(fnt_waddr_o) * 256 + int'(fnt_wdata_o), e_fa * 256 + e_fd);
   endtask

   task automatic check_read(bit w, int a, int hi, int lo);
      int e;
      int lb, hb;
      if (a < 'h4000 || a >= 'h5000) e = 'hFFFF;
      else begin
         if (a % 2 == 0) begin
            lb = fv(lo + (a / 2) % 16); hb = fv(hi + (a / 2) % 16);
         end else begin
            lb = fv(hi + (a / 2) % 16); hb = fv(lo + ((a + 1) / 2) % 16);
         end
         e = (!w || a == 'h4FFF) ? ('hFF00 + lb) : (hb * 256 + lb);
      end
      chk(int'(rdata_o) == e, (e == 'hFFFF) ? "R10" : "R5", $sformatf("read @%0h w=%0d", a, w),
          int'(rdata_o), e);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk_i);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk_i);
      // R11: flags start clear
      chk(text_dirty_o == 1'b0 && font_flag_o == 1'b0, "R11", "reset flags",
          int'({text_dirty_o, font_flag_o}), 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk(text_dirty_o == 1'b0 && font_flag_o == 1'b0, "R11", "flags after reset",
          int'({text_dirty_o, font_flag_o}), 0);

      // R10: a write without req does nothing
      we_i = 1'b1; addr_i = 15'h0010; wdata_i = 16'h1234;
      #1;
      chk(txt_we_o == 2'b00 && !fnt_we_o, "R10", "no req write", int'(txt_we_o), 0);
      @(negedge clk_i);
      chk(!text_dirty_o, "R10", "no req flag", int'(text_dirty_o), 0);

      // R1 R2 R3 R4 R6 R7 R10: write sweeps
      for (int mode = 0; mode < 2; mode++) begin
         for (int w = 0; w < 2; w++) begin
            for (int a = 0; a < 'h5100; a++) begin
               @(negedge clk_i);
               req_i = 1'b1; we_i = 1'b1; word_i = 1'(w);
               sw_en_i = 1'(mode); font_wen_i = 1'(mode);
               addr_i = 15'(a);
               wdata_i = 16'((a * 40503 + 7) % 65536);
               font_hi_i = 8'((a * 13) % 256);
               #1;
               check_write(1'(w), a, int'(wdata_i), 1'(mode), 1'(mode), int'(font_hi_i));
            end
         end
      end

      // R5: read sweep across the character window edges
      for (int w = 0; w < 2; w++) begin
         for (int a = 'h3F00; a < 'h5100; a++) begin
            @(negedge clk_i);
            req_i = 1'b1; we_i = 1'b0; word_i = 1'(w);
            addr_i = 15'(a);
            font_hi_i = 8'((a * 29 + 5) % 256);
            font_lo_i = 8'((a * 71 + 200) % 256);
            #1;
            check_read(1'(w), a, int'(font_hi_i), int'(font_lo_i));
         end
      end

      // R8: sticky text flag
      @(negedge clk_i); req_i = 1'b0; clr_i = 1'b1;
      @(negedge clk_i); clr_i = 1'b0;
      chk(!text_dirty_o && !font_flag_o, "R8", "cleared", int'({text_dirty_o, font_flag_o}), 0);
      req_i = 1'b1; we_i = 1'b1; word_i = 1'b0; addr_i = 15'h2001; sw_en_i = 1'b0; font_wen_i = 1'b0;
      @(negedge clk_i); req_i = 1'b0;
      chk(!text_dirty_o, "R8", "rejected write leaves flag", int'(text_dirty_o), 0);
      req_i = 1'b1; addr_i = 15'h0100;
      @(negedge clk_i); req_i = 1'b0;
      chk(text_dirty_o, "R8", "set after write", int'(text_dirty_o), 1);
      repeat (3) @(negedge clk_i);
      chk(text_dirty_o, "R8", "held while idle", int'(text_dirty_o), 1);
      clr_i = 1'b1;
      @(negedge clk_i); clr_i = 1'b0;
      chk(!text_dirty_o, "R8", "cleared by strobe", int'(text_dirty_o), 0);
      clr_i = 1'b1; req_i = 1'b1; addr_i = 15'h0200;
      @(negedge clk_i); clr_i = 1'b0; req_i = 1'b0;
      chk(text_dirty_o, "R8", "write beats clear", int'(text_dirty_o), 1);

      // R9: font flag
      clr_i = 1'b1;
      @(negedge clk_i); clr_i = 1'b0;
      req_i = 1'b1; addr_i = 15'h4003; font_wen_i = 1'b0;
      @(negedge clk_i); req_i = 1'b0;
      chk(!font_flag_o, "R9", "disabled font write", int'(font_flag_o), 0);
      req_i = 1'b1; font_wen_i = 1'b1;
      @(negedge clk_i); req_i = 1'b0;
      chk(font_flag_o && !text_dirty_o, "R9", "font write sets flag only",
          int'({font_flag_o, text_dirty_o}), 2);
      clr_i = 1'b1; req_i = 1'b1;
      @(negedge clk_i); clr_i = 1'b0; req_i = 1'b0;
      chk(font_flag_o, "R9", "font write beats clear", int'(font_flag_o), 1);
      clr_i = 1'b1;
      @(negedge clk_i); clr_i = 1'b0;
      chk(!font_flag_o, "R9", "cleared by strobe", int'(font_flag_o), 0);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule